// File: doc/BRIEF.md
# Doppler Search Peak Detector for Code-Phase Acquisition

This block sequences the Doppler dimension of a parallel code-phase acquisition and makes the detect/no-detect call. After a start pulse it walks a bin index from the lowest to the highest Doppler offset and presents the matching carrier offset in hertz, from -5000 Hz to +5000 Hz in 250 Hz steps (41 bins). For each bin an external FFT correlator delivers one transform's worth of correlation magnitudes as a valid-qualified stream. Only the first `PHASES` positions of each transform are real code-phase bins (one millisecond at 10 MHz, 10,000 bins). The remaining positions up to the transform length of 16,384 are padding.

Across the whole search the block keeps the strongest peak and a runner-up. A runner-up candidate that lies within `EXCL` samples of the current strongest peak in the same Doppler bin is rejected, with the distance taken circularly over the code period. When a new strongest peak displaces the old one, the old one becomes the runner-up unless it sits inside the new peak's window. Each bin uses exactly one transform and nothing is accumulated between bins. At the end the block reports the winning bin, the code phase, the peak magnitude and a detect flag. The flag is set when the peak is at least 1.5 times the runner-up, and it is evaluated without a divider.

Top module: `acq_peak_search`

## Requirements
- R1: After reset `busy`, `done`, `bin_idx`, `res_bin`, `res_phase`, `res_peak` and `res_acq` are all 0.
- R2: A `start` pulse while `busy` is 0 sets `busy` and restarts at bin 0 on the next cycle. A `start` while `busy` is 1 has no effect on the bin position or the search.
- R3: Bins are visited in ascending order 0 to `NUM_BINS-1`. Each bin lasts exactly `FFT_LEN` accepted samples, and `carrier_hz` equals -5000 + 250 × `bin_idx`.
- R4: Cycles with `mag_valid` low are not counted and their data is ignored. Stream positions `PHASES` to `FFT_LEN-1` of every bin are ignored whatever their magnitude.
- R5: The reported peak is the strictly largest magnitude seen. On equal magnitudes the earliest sample (lowest bin, then lowest phase) wins. `res_bin` is below `NUM_BINS` and `res_phase` is below `PHASES`.
- R6: A runner-up candidate in the same bin as the current peak is rejected when its circular distance from the peak phase, modulo `PHASES`, is at most `EXCL`.
- R7: A displaced peak becomes the runner-up, unless it lies inside the new peak's exclusion window (R6), in which case the runner-up is unchanged.
- R8: `res_acq` is 1 exactly when 2 × peak ≥ 3 × runner-up. Equality counts as detected.
- R9: `busy` falls and `done` rises one cycle after the last sample of the last bin is accepted. `done` and the results then hold until the next accepted `start`, which clears `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search when idle |
| mag_valid | input | 1 | Qualifies `mag_data` |
| mag_data | input | MAG_W | Correlation magnitude for the current stream position |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished, results valid |
| bin_idx | output | BIN_W | Current Doppler bin index |
| carrier_hz | output | HZ_W | Signed carrier offset of the current bin in Hz |
| res_bin | output | BIN_W | Doppler bin of the peak |
| res_phase | output | PH_W | Code phase of the peak |
| res_peak | output | MAG_W | Peak magnitude |
| res_acq | output | 1 | Detect flag from the peak-ratio test |

## Verification
The stream patterns are chosen so that each rule changes the outcome. A lone strong peak gives a clean detection. A strong peak with a close neighbour just across the code-period wrap only detects if the circular exclusion works. Runner-up values of exactly two thirds of the peak and one count above it pin the ratio boundary. Huge padding values and high-valued idle cycles only leave the result intact if they are ignored. Further runs displace an earlier peak from another bin and from the same bin, pitting demotion against exclusion. Two equal peaks check the tie order. A start pulse in mid-search checks that it is ignored. Every cycle is also compared with a behavioural model of the whole search.

// File: rtl/acq_peak_search.sv
module acq_peak_search #(
  parameter int NUM_BINS = 41,
  parameter int PHASES   = 10000,
  parameter int FFT_LEN  = 16384,
  parameter int MAG_W    = 24,
  parameter int EXCL     = 10,
  parameter int DOP_MIN  = -5000,
  parameter int DOP_STEP = 250,
  parameter int HZ_W     = 16,
  localparam int BIN_W   = $clog2(NUM_BINS),
  localparam int PH_W    = $clog2(PHASES),
  localparam int POS_W   = $clog2(FFT_LEN)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   mag_valid,
  input  logic [MAG_W-1:0]       mag_data,
  output logic                   busy,
  output logic                   done,
  output logic [BIN_W-1:0]       bin_idx,
  output logic signed [HZ_W-1:0] carrier_hz,
  output logic [BIN_W-1:0]       res_bin,
  output logic [PH_W-1:0]        res_phase,
  output logic [MAG_W-1:0]       res_peak,
  output logic                   res_acq
);

  localparam logic [POS_W-1:0] POS_LAST = POS_W'(FFT_LEN - 1);
  localparam logic [BIN_W-1:0] BIN_LAST = BIN_W'(NUM_BINS - 1);
  localparam logic [POS_W:0]   PH_LIM   = (POS_W+1)'(PHASES);
  localparam logic [PH_W:0]    EXCL_V   = (PH_W+1)'(EXCL);
  localparam logic [PH_W:0]    WRAP_V   = (PH_W+1)'(PHASES - EXCL);

  logic [POS_W-1:0] pos;
  logic [MAG_W-1:0] best_v, sec_v, best_vn, sec_vn;
  logic [BIN_W-1:0] best_b, best_bn;
  logic [PH_W-1:0]  best_p, best_pn, cur_p;
  logic             take, in_data, near_cur;
  logic [MAG_W+1:0] twice_best, thrice_sec;
  int               hz_i;

  function automatic logic near(input logic [PH_W-1:0] a, input logic [PH_W-1:0] b);
    logic [PH_W:0] d;
    d = (a > b) ? ({1'b0, a} - {1'b0, b}) : ({1'b0, b} - {1'b0, a});
    return (d <= EXCL_V) || (d >= WRAP_V);
  endfunction

  assign take     = busy & mag_valid;
  assign in_data  = {1'b0, pos} < PH_LIM;
  assign cur_p    = pos[PH_W-1:0];
  assign near_cur = (bin_idx == best_b) && near(cur_p, best_p);

  always_comb hz_i = DOP_MIN + DOP_STEP * int'(bin_idx);
  assign carrier_hz = hz_i[HZ_W-1:0];

  always_comb begin
    best_vn = best_v;
    best_bn = best_b;
    best_pn = best_p;
    sec_vn  = sec_v;
    if (take && in_data) begin
      if (mag_data > best_v) begin
        best_vn = mag_data;
        best_bn = bin_idx;
        best_pn = cur_p;
        if (!near_cur) sec_vn = best_v;
      end else if (!near_cur && mag_data > sec_v) begin
        sec_vn = mag_data;
      end
    end
  end

  assign twice_best = {1'b0, best_vn, 1'b0};
  assign thrice_sec = {1'b0, sec_vn, 1'b0} + {2'b00, sec_vn};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      bin_idx   <= '0;
      pos       <= '0;
      best_v    <= '0;
      best_b    <= '0;
      best_p    <= '0;
      sec_v     <= '0;
      res_bin   <= '0;
      res_phase <= '0;
      res_peak  <= '0;
      res_acq   <= 1'b0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      done    <= 1'b0;
      bin_idx <= '0;
      pos     <= '0;
      best_v  <= '0;
      best_b  <= '0;
      best_p  <= '0;
      sec_v   <= '0;
    end else if (take) begin
      best_v <= best_vn;
      best_b <= best_bn;
      best_p <= best_pn;
      sec_v  <= sec_vn;
      if (pos == POS_LAST) begin
        pos <= '0;
        if (bin_idx == BIN_LAST) begin
          busy      <= 1'b0;
          done      <= 1'b1;
          bin_idx   <= '0;
          res_bin   <= best_bn;
          res_phase <= best_pn;
          res_peak  <= best_vn;
          res_acq   <= twice_best >= thrice_sec;
        end else begin
          bin_idx <= bin_idx + 1'b1;
        end
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

endmodule

// File: rtl/acq_peak_search_chk.sv
module acq_peak_search_chk #(
  parameter int NUM_BINS = 41,
  parameter int PHASES   = 10000,
  parameter int FFT_LEN  = 16384,
  parameter int MAG_W    = 24,
  parameter int HZ_W     = 16,
  localparam int BIN_W   = $clog2(NUM_BINS),
  localparam int PH_W    = $clog2(PHASES)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic                   mag_valid,
  input logic [MAG_W-1:0]       mag_data,
  input logic                   busy,
  input logic                   done,
  input logic [BIN_W-1:0]       bin_idx,
  input logic signed [HZ_W-1:0] carrier_hz,
  input logic [BIN_W-1:0]       res_bin,
  input logic [PH_W-1:0]        res_phase,
  input logic [MAG_W-1:0]       res_peak,
  input logic                   res_acq
);

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && bin_idx == '0));

  assert_bin_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (int'(bin_idx) == int'($past(bin_idx)) ||
                               int'(bin_idx) == int'($past(bin_idx)) + 1));

  assert_bin_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> int'(bin_idx) < NUM_BINS);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_fall_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> ($stable(res_peak) && $stable(res_bin) &&
                               $stable(res_phase) && $stable(res_acq)));

  assert_res_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(res_bin) < NUM_BINS && int'(res_phase) < PHASES));

endmodule

bind acq_peak_search acq_peak_search_chk #(
  .NUM_BINS(NUM_BINS), .PHASES(PHASES), .FFT_LEN(FFT_LEN),
  .MAG_W(MAG_W), .HZ_W(HZ_W)
) chk_i (.*);

// File: tb/acq_peak_search_tb_top.sv
module acq_peak_search_tb_top;
  localparam int NB = 41, PH = 100, FL = 128, MW = 24, EX = 10;
  localparam int BW = $clog2(NB), PW = $clog2(PH);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mag_valid = 1'b0;
  logic [MW-1:0] mag_data = '0;
  logic busy, done, res_acq;
  logic [BW-1:0] bin_idx, res_bin;
  logic signed [15:0] carrier_hz;
  logic [PW-1:0] res_phase;
  logic [MW-1:0] res_peak;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  acq_peak_search #(.NUM_BINS(NB), .PHASES(PH), .FFT_LEN(FL), .MAG_W(MW), .EXCL(EX)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mag_valid(mag_valid), .mag_data(mag_data),
    .busy(busy), .done(done), .bin_idx(bin_idx), .carrier_hz(carrier_hz),
    .res_bin(res_bin), .res_phase(res_phase), .res_peak(res_peak), .res_acq(res_acq));

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference of the search
  int m_busy = 0, m_done = 0, m_bin = 0, m_pos = 0;
  int bv = 0, bb = 0, bp = 0, sv = 0;
  int r_bin = 0, r_ph = 0, r_pk = 0, r_acq = 0;

  function automatic bit excluded(int b, int p);
    int d;
    d = (p > bp) ? p - bp : bp - p;
    return (b == bb) && (d <= EX || d >= PH - EX);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_bin = 0; m_pos = 0;
      bv = 0; bb = 0; bp = 0; sv = 0;
      r_bin = 0; r_ph = 0; r_pk = 0; r_acq = 0;
    end else if (start && m_busy == 0) begin
      m_busy = 1; m_done = 0; m_bin = 0; m_pos = 0;
      bv = 0; bb = 0; bp = 0; sv = 0;
    end else if (m_busy != 0 && mag_valid) begin
      if (m_pos < PH) begin
        int v;
        v = int'(mag_data);
        if (v > bv) begin
          if (!excluded(m_bin, m_pos)) sv = bv;
          bv = v; bb = m_bin; bp = m_pos;
        end else if (!excluded(m_bin, m_pos) && v > sv) begin
          sv = v;
        end
      end
      if (m_pos == FL - 1) begin
        m_pos = 0;
        if (m_bin == NB - 1) begin
          m_busy = 0; m_done = 1; m_bin = 0;
          r_bin = bb; r_ph = bp; r_pk = bv; r_acq = (2 * bv >= 3 * sv) ? 1 : 0;
        end else m_bin++;
      end else m_pos++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 busy vs model", busy, m_busy);
      chk("R9 done vs model", done, m_done);
      chk("R3 bin vs model", bin_idx, m_bin);
      chk("R5 res_bin vs model", res_bin, r_bin);
      chk("R5 res_phase vs model", res_phase, r_ph);
      chk("R5 res_peak vs model", res_peak, r_pk);
      chk("R8 res_acq vs model", res_acq, r_acq);
    end
  end

  function automatic int gen(int s, int b, int p);
    int n;
    if (p >= PH) return (s == 3) ? 5000 : (p * 3) % 40;
    n = (p * 7 + b * 13) % 50;
    case (s)
      0: if (b == 17 && p == 42) n = 1000; else if (b == 3 && p == 10) n = 500;
      1: if (b == 5 && p == 2) n = 900; else if (b == 5 && p == 95) n = 800;
         else if (b == 30 && p == 0) n = 600;
      2: if (b == 5 && p == 2) n = 900; else if (b == 30 && p == 0) n = 601;
      3: if (b == 40 && p == 99) n = 700; else if (b == 0 && p == 0) n = 300;
      4: if (b == 2 && p == 50) n = 800; else if (b == 9 && p == 50) n = 1000;
      5: if (b == 9 && p == 40) n = 800; else if (b == 9 && p == 45) n = 1000;
      6: if (b == 1 && p == 3) n = 700; else if (b == 20 && p == 60) n = 700;
      default: ;
    endcase
    return n;
  endfunction

  task automatic run_search(input int s, input bit gaps);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int b = 0; b < NB; b++) begin
      for (int p = 0; p < FL; p++) begin
        if (p == 0) begin
          chk("R3 bin order", bin_idx, b);
          chk("R3 carrier offset", carrier_hz, -5000 + 250 * b);
        end
        if (gaps && p % 7 == 3) begin
          mag_valid = 1'b0; mag_data = '1;
          @(negedge clk);
        end
        mag_valid = 1'b1;
        mag_data = MW'(gen(s, b, p));
        if (s == 0 && b == 2 && p == 0) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (s == 0 && b == 2 && p == 0) begin
          chk("R2 start ignored while busy", busy, 1);
          chk("R2 bin kept on start while busy", bin_idx, 2);
        end
      end
    end
    mag_valid = 1'b0; mag_data = '0;
    chk("R9 done after last sample", done, 1);
    chk("R9 busy low after last sample", busy, 0);
  endtask

  task automatic expect_res(input string tag, input int b, input int p, input int pk, input int acq);
    chk({tag, " bin"}, res_bin, b);
    chk({tag, " phase"}, res_phase, p);
    chk({tag, " peak"}, res_peak, pk);
    chk({tag, " acq"}, res_acq, acq);
    repeat (5) @(negedge clk);
    chk("R9 results held", res_peak, pk);
    chk("R9 done held", done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy at reset", busy, 0);
    chk("R1 done at reset", done, 0);
    chk("R1 bin at reset", bin_idx, 0);
    chk("R1 res_peak at reset", res_peak, 0);
    chk("R1 res_bin at reset", res_bin, 0);
    chk("R1 res_phase at reset", res_phase, 0);
    chk("R1 res_acq at reset", res_acq, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_search(0, 1'b1); expect_res("R5 single peak", 17, 42, 1000, 1);
    run_search(1, 1'b0); expect_res("R6 wrap exclusion", 5, 2, 900, 1);
    run_search(2, 1'b0); expect_res("R8 ratio just below", 5, 2, 900, 0);
    run_search(3, 1'b1); expect_res("R4 padding and idle ignored", 40, 99, 700, 1);
    run_search(4, 1'b0); expect_res("R7 demotion", 9, 50, 1000, 0);
    run_search(5, 1'b0); expect_res("R7 demotion blocked by window", 9, 45, 1000, 1);
    run_search(6, 1'b1); expect_res("R5 tie keeps earliest", 1, 3, 700, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule